// File: doc/BRIEF.md
# I2C Target Byte Engine

This block lets a chip answer as a target on a two-wire I2C bus. It samples SCL and SDA with the system clock through a short synchronizer and finds START and STOP conditions from those samples. It shifts in the first byte after each START and compares its upper seven bits with a programmable own address. When the run-time enable is set, it also recognises the all-zero general-call address. A matching address is acknowledged, and the read/write bit selects whether the engine receives or transmits the bytes that follow.

Firmware works with the engine through a plain parallel interface. The engine provides a received-byte output, a transmit-byte input with a load strobe, and a take strobe for received data. It also reports flags for bus busy, START seen, end of byte, direction, selection, general-call hit and bus error. After every acknowledge slot the engine holds SCL low. It keeps holding until firmware touches the data path, so software can take its time on each byte. Both bus outputs are pull-low requests for open-drain pads and never drive a line high.

Top module: `i2c_target_engine`

## Requirements
- R1: A START (SDA falls while SCL is high) sets busy_o and start_flag_o. A STOP (SDA rises while SCL is high) clears busy_o and releases both sda_pull_o and scl_hold_o.
- R2: The address byte is shifted in most significant bit first. If bits [7:1] equal a nonzero own_addr_i, the engine pulls SDA low during the ninth clock, sets selected_o and copies the byte to rx_byte_o.
- R3: A non-matching address gets no acknowledge. The rest of the transfer up to the next START is ignored: rx_byte_o is unchanged, byte_done_o stays low and SCL is never held.
- R4: The address byte 0x00 is acknowledged as a general call, with gc_hit_o set, only while gc_en_i is 1. Byte 0x01 is never a general call.
- R5: tx_mode_o takes bit 0 of a matched address byte (1 means the engine transmits).
- R6: In receive mode each data byte appears on rx_byte_o after its eighth bit. The engine acknowledges it when ack_en_i is 1 and leaves SDA released (NACK) when ack_en_i is 0.
- R7: At the end of each acknowledged address or data slot the engine sets byte_done_o and holds SCL low. A pulse on rx_take_i or tx_load_i releases SCL and clears byte_done_o, start_flag_o and bus_err_o.
- R8: In transmit mode the byte given with tx_load_i is sent most significant bit first. SDA is pulled low for 0 bits and released for 1 bits, and it changes only while SCL is low.
- R9: A NACK from the controller after a transmitted byte makes the engine release SDA and stop. It does not hold SCL and ignores clocks until the next START.
- R10: A START or STOP after 1 to 7 bits of a byte sets bus_err_o, clears selected_o and aborts the transfer. Clocks that follow get no response until the next START.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_hold_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| own_addr_i | input | 7 | Own 7-bit target address |
| gc_en_i | input | 1 | Allow general-call recognition |
| ack_en_i | input | 1 | Acknowledge received data bytes |
| tx_byte_i | input | 8 | Next byte to transmit |
| tx_load_i | input | 1 | Load tx_byte_i and release a stretch |
| rx_take_i | input | 1 | Firmware took the received byte; releases a stretch |
| rx_byte_o | output | 8 | Last received address or data byte |
| busy_o | output | 1 | Bus between START and STOP |
| start_flag_o | output | 1 | A START was seen |
| byte_done_o | output | 1 | A byte and its acknowledge slot finished |
| tx_mode_o | output | 1 | Direction from the matched R/W bit |
| selected_o | output | 1 | Engine is addressed |
| gc_hit_o | output | 1 | Selection came from the general call |
| bus_err_o | output | 1 | Misplaced START or STOP seen |

## Verification
If the bit counter or the state is wrong, the fault shows on SDA within one byte. An acknowledge then lands on the wrong clock or goes missing, or a transmitted bit is shifted. The bench catches this when it samples SDA at the middle of each SCL-high phase. A stretch that never releases shows up as SCL held low at the next bit, and a stretch that fails to start shows as scl_hold_o low right after the ninth clock. A wrong decision in error or STOP handling appears as bus_err_o, busy_o or selected_o with the wrong value a few cycles after the condition, or as the engine answering a byte it should ignore.

// File: rtl/i2c_target_engine.sv
module i2c_target_engine #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_hold_o,
  output logic       sda_pull_o,
  input  logic [6:0] own_addr_i,
  input  logic       gc_en_i,
  input  logic       ack_en_i,
  input  logic [7:0] tx_byte_i,
  input  logic       tx_load_i,
  input  logic       rx_take_i,
  output logic [7:0] rx_byte_o,
  output logic       busy_o,
  output logic       start_flag_o,
  output logic       byte_done_o,
  output logic       tx_mode_o,
  output logic       selected_o,
  output logic       gc_hit_o,
  output logic       bus_err_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK
  } state_t;

  state_t state;
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       nack_q;

  wire scl_s     = scl_sync[SYNC_STAGES-1];
  wire sda_s     = sda_sync[SYNC_STAGES-1];
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire in_byte   = (state == S_ADDR) || (state == S_RX) || (state == S_TX);
  wire mid_byte  = in_byte && (bitcnt != 4'd0) && (bitcnt < 4'd8);
  wire own_hit   = (shreg[7:1] == own_addr_i) && (own_addr_i != 7'd0);
  wire gc_now    = gc_en_i && (shreg == 8'h00);
  wire access    = rx_take_i | tx_load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync     <= '1;
      sda_sync     <= '1;
      scl_p        <= 1'b1;
      sda_p        <= 1'b1;
      state        <= S_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      nack_q       <= 1'b0;
      scl_hold_o   <= 1'b0;
      sda_pull_o   <= 1'b0;
      rx_byte_o    <= '0;
      busy_o       <= 1'b0;
      start_flag_o <= 1'b0;
      byte_done_o  <= 1'b0;
      tx_mode_o    <= 1'b0;
      selected_o   <= 1'b0;
      gc_hit_o     <= 1'b0;
      bus_err_o    <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;

      if (access) begin
        byte_done_o  <= 1'b0;
        start_flag_o <= 1'b0;
        bus_err_o    <= 1'b0;
        if (scl_hold_o) begin
          scl_hold_o <= 1'b0;
          if (state == S_TX && tx_load_i) begin
            shreg      <= tx_byte_i;
            sda_pull_o <= ~tx_byte_i[7];
          end
        end
      end

      if (stop_det) begin
        busy_o     <= 1'b0;
        state      <= S_IDLE;
        sda_pull_o <= 1'b0;
        scl_hold_o <= 1'b0;
        selected_o <= 1'b0;
        if (mid_byte) bus_err_o <= 1'b1;
      end else if (start_det) begin
        busy_o       <= 1'b1;
        start_flag_o <= 1'b1;
        sda_pull_o   <= 1'b0;
        scl_hold_o   <= 1'b0;
        selected_o   <= 1'b0;
        gc_hit_o     <= 1'b0;
        bitcnt       <= '0;
        if (mid_byte) begin
          bus_err_o <= 1'b1;
          state     <= S_IDLE;
        end else begin
          state <= S_ADDR;
        end
      end else if (scl_rise) begin
        case (state)
          S_ADDR, S_RX: begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          S_TX:     bitcnt <= bitcnt + 4'd1;
          S_TX_ACK: nack_q <= sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          S_ADDR: if (bitcnt == 4'd8) begin
            if (own_hit || gc_now) begin
              rx_byte_o  <= shreg;
              sda_pull_o <= 1'b1;
              selected_o <= 1'b1;
              tx_mode_o  <= shreg[0];
              gc_hit_o   <= gc_now;
              state      <= S_ADDR_ACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_RX: if (bitcnt == 4'd8) begin
            rx_byte_o  <= shreg;
            sda_pull_o <= ack_en_i;
            state      <= S_RX_ACK;
          end
          S_TX: begin
            if (bitcnt == 4'd8) begin
              sda_pull_o <= 1'b0;
              state      <= S_TX_ACK;
            end else if (bitcnt != 4'd0) begin
              sda_pull_o <= ~shreg[6];
              shreg      <= {shreg[6:0], 1'b0};
            end
          end
          S_ADDR_ACK, S_RX_ACK: begin
            sda_pull_o  <= 1'b0;
            byte_done_o <= 1'b1;
            scl_hold_o  <= 1'b1;
            bitcnt      <= '0;
            state       <= (state == S_ADDR_ACK && tx_mode_o) ? S_TX : S_RX;
          end
          S_TX_ACK: begin
            bitcnt <= '0;
            if (nack_q) begin
              state <= S_IDLE;
            end else begin
              byte_done_o <= 1'b1;
              scl_hold_o  <= 1'b1;
              state       <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy_o);

  assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull_o && !scl_hold_o && !busy_o));

  assert_gc_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_hit_o) |-> $past(gc_en_i));

  assert_hold_only_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o |-> byte_done_o);

  assert_sda_steady_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p && !start_det && !stop_det) |=> $stable(sda_pull_o));

  assert_error_deselects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err_o) |-> !selected_o);

endmodule

// File: tb/i2c_target_engine_tb.sv
module i2c_target_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  // {own[26:20], gc_en[19], ack_en[18], addr[17:10], data[9:2], exp_ack[1], exp_gc[0]}
  localparam logic [26:0] VEC [0:7] = '{
    {7'h3A, 1'b0, 1'b1, 8'h74, 8'hC5, 1'b1, 1'b0},
    {7'h3A, 1'b0, 1'b1, 8'h75, 8'h96, 1'b1, 1'b0},
    {7'h3A, 1'b0, 1'b1, 8'h76, 8'h00, 1'b0, 1'b0},
    {7'h11, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b1},
    {7'h11, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
    {7'h11, 1'b1, 1'b1, 8'h01, 8'h00, 1'b0, 1'b0},
    {7'h7F, 1'b0, 1'b0, 8'hFE, 8'h81, 1'b1, 1'b0},
    {7'h40, 1'b1, 1'b1, 8'h81, 8'h00, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [6:0] own_addr = 7'h3A;
  logic gc_en = 0, ack_en = 1, tx_load = 0, rx_take = 0;
  logic [7:0] tx_byte = 0;
  logic scl_hold, sda_pull, busy, start_flag, byte_done, tx_mode, selected, gc_hit, bus_err;
  logic [7:0] rx_byte;
  logic scl_bus, sda_bus;
  int total = 0, fails = 0;

  assign scl_bus = scl_m & ~scl_hold;
  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_target_engine u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_hold_o(scl_hold), .sda_pull_o(sda_pull),
    .own_addr_i(own_addr), .gc_en_i(gc_en), .ack_en_i(ack_en),
    .tx_byte_i(tx_byte), .tx_load_i(tx_load), .rx_take_i(rx_take),
    .rx_byte_o(rx_byte), .busy_o(busy), .start_flag_o(start_flag),
    .byte_done_o(byte_done), .tx_mode_o(tx_mode), .selected_o(selected),
    .gc_hit_o(gc_hit), .bus_err_o(bus_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk(req, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1;
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic got);
    sda_m = b; wait_q(Q);
    scl_up(); wait_q(Q);
    got = sda_bus;
    scl_m = 0; wait_q(Q);
  endtask

  task automatic send_start();
    sda_m = 1; wait_q(Q);
    scl_up(); wait_q(Q);
    sda_m = 0; wait_q(Q);
    scl_m = 0; wait_q(Q);
  endtask

  task automatic send_stop();
    sda_m = 0; wait_q(Q);
    scl_up(); wait_q(Q);
    sda_m = 1; wait_q(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], d);
    bit_xfer(1'b1, ack);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] v);
    logic d;
    for (int i = 7; i >= 0; i--) bit_xfer(1'b1, v[i]);
    bit_xfer(nack, d);
  endtask

  task automatic take();
    rx_take = 1; @(negedge clk); rx_take = 0; wait_q(2);
  endtask

  task automatic load(input logic [7:0] v);
    tx_byte = v; tx_load = 1; @(negedge clk); tx_load = 0; wait_q(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic a, a2;
    logic [7:0] got, prev;
    wait_q(4);
    // R11 reset state
    chk("R11", {scl_hold, sda_pull, busy, start_flag, byte_done, tx_mode, selected, gc_hit}, 8'h00);
    chk("R11", {7'd0, bus_err}, 8'h00);
    chk("R11", rx_byte, 8'h00);
    rst_n = 1; wait_q(4);

    for (int i = 0; i < 8; i++) begin
      logic [26:0] v;
      v = VEC[i];
      own_addr = v[26:20]; gc_en = v[19]; ack_en = v[18];
      prev = rx_byte;
      send_start();
      chk1("R1", busy, 1'b1);
      chk1("R1", start_flag, 1'b1);
      write_byte(v[17:10], a);
      chk1("R2", a, ~v[1]);
      if (v[1]) begin
        chk1("R2", selected, 1'b1);
        chk("R2", rx_byte, v[17:10]);
        chk1("R4", gc_hit, v[0]);
        chk1("R5", tx_mode, v[10]);
        chk1("R7", byte_done, 1'b1);
        chk1("R7", scl_hold, 1'b1);
        if (!v[10]) begin
          take();
          chk1("R7", scl_hold, 1'b0);
          chk1("R7", start_flag, 1'b0);
          write_byte(v[9:2], a2);
          chk1("R6", a2, ~v[18]);
          chk("R6", rx_byte, v[9:2]);
          chk1("R7", byte_done, 1'b1);
          take();
          chk1("R7", byte_done, 1'b0);
        end else begin
          load(v[9:2]);
          chk1("R7", scl_hold, 1'b0);
          read_byte(1'b1, got);
          chk("R8", got, v[9:2]);
          chk1("R9", sda_pull, 1'b0);
          chk1("R9", scl_hold, 1'b0);
        end
      end else begin
        chk1("R3", selected, 1'b0);
        chk1("R3", byte_done, 1'b0);
        chk1("R3", scl_hold, 1'b0);
        chk("R3", rx_byte, prev);
        chk1("R4", gc_hit, 1'b0);
      end
      send_stop();
      chk1("R1", busy, 1'b0);
      chk1("R1", sda_pull, 1'b0);
    end

    // two-byte read, first acknowledged: R7, R8
    own_addr = 7'h3A;
    send_start();
    write_byte(8'h75, a);
    chk1("R2", a, 1'b0);
    load(8'hA5);
    read_byte(1'b0, got);
    chk("R8", got, 8'hA5);
    chk1("R7", byte_done, 1'b1);
    chk1("R7", scl_hold, 1'b1);
    load(8'h3C);
    read_byte(1'b1, got);
    chk("R8", got, 8'h3C);
    chk1("R9", scl_hold, 1'b0);
    write_byte(8'h00, a);
    chk1("R9", a, 1'b1);
    send_stop();

    // misplaced STOP after three address bits: R10
    send_start();
    bit_xfer(1'b0, a); bit_xfer(1'b1, a); bit_xfer(1'b1, a);
    sda_m = 0; wait_q(Q);
    scl_up(); wait_q(Q);
    sda_m = 1; wait_q(Q);
    chk1("R10", bus_err, 1'b1);
    chk1("R1", busy, 1'b0);
    take();
    chk1("R7", bus_err, 1'b0);

    // misplaced START in a data byte: R10
    send_start();
    write_byte(8'h74, a);
    chk1("R2", a, 1'b0);
    take();
    bit_xfer(1'b1, a); bit_xfer(1'b0, a);
    sda_m = 1; wait_q(Q);
    scl_up(); wait_q(Q);
    sda_m = 0; wait_q(Q);
    chk1("R10", bus_err, 1'b1);
    chk1("R10", selected, 1'b0);
    chk1("R1", busy, 1'b1);
    scl_m = 0; wait_q(Q);
    write_byte(8'h74, a);
    chk1("R10", a, 1'b1);
    chk1("R10", scl_hold, 1'b0);
    send_stop();
    chk1("R1", busy, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule